// File: doc/BRIEF.md
# Successive-Approximation Converter Register Interface and Sequencer

This block is the digital side of an eight-input, 10-bit successive-approximation converter. Software reaches it through four byte-wide registers on a simple register bus. Two registers hold the result and are read-only. The control register selects the channel, sets how many port pins act as analog inputs, starts a conversion and shows whether one is in progress. The clock-setting register picks the converter clock divider.

Software starts a conversion by writing START high and then low. The in-progress flag goes high on the first write. The conversion runs after the second write. It uses one sample period followed by ten comparator trials, most significant bit first. Each trial lasts one converter clock period. The block drives a trial code towards an external DAC and reads back a single comparator bit. At the end it loads the result registers and clears the flag.

The port configuration field decides which pins leave digital service. A pin in analog mode has its digital buffer and pull-up turned off. The analog section is powered whenever any pin is analog.

Top module: `adc_ctrl`

## Requirements
- R1: The registers sit at base address 24h and read as follows. Register 24h holds the low result bits in bits 7:6, and its other bits read 0. Register 25h holds result bits 9:2. Register 26h holds START in bit 7, the busy flag in bit 6, the pin configuration in bits 5:3 and the channel in bits 2:0. Register 27h holds the test bit in bit 7 and the divider select in bits 1:0, and its bits 6:2 read 0. Any other address reads 0, and every register reads 0 after reset.
- R2: A write to 24h or 25h has no effect, and neither does a write to bit 6 of 26h.
- R3: Writing START from 0 to 1 sets the busy flag, and it reads 1 on the next cycle.
- R4: While START stays at 1, no conversion runs. The flag stays 1 and the result registers keep their value.
- R5: The busy flag clears exactly 11*D clock cycles after the write that takes START from 1 to 0. D is 2, 8 or 32 for divider select 00, 01 or 10. Select 11 uses 32.
- R6: With a comparator that reports input >= trial code, the result equals the input code, including codes 0 and 1023.
- R7: The result registers change only when a conversion completes.
- R8: Writing START from 0 to 1 during a conversion aborts it. The flag stays 1 and the result stays unchanged until the next falling write, and then a full new conversion runs.
- R9: sample_o is high for exactly the first D cycles of a conversion.
- R10: Pin configuration code 0 leaves every pin digital. Code k from 1 to 7 makes pins 0 through k analog. adc_power_o is high when any pin is analog. chan_sel_o equals control bits 2:0.
- R11: adc_clk_o stays low while idle. During a conversion it completes one period of D cycles per step, which gives 11 rising edges per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| cmp_i | input | 1 | Comparator: 1 when input >= DAC code |
| dac_code_o | output | 10 | Trial code towards the DAC |
| sample_o | output | 1 | Sample phase active |
| adc_clk_o | output | 1 | Divided converter clock |
| chan_sel_o | output | 3 | Analog channel select |
| analog_en_o | output | 8 | Per-pin analog mode; 1 disables the digital buffer and pull-up |
| adc_power_o | output | 1 | Analog section power enable |

## Verification
The bench uses the default parameters: base address 24h, 10-bit resolution, eight pins and dividers of 2, 8 and 32. These values let it reach both ends of the code range and all four divider selects, including the fallback code. They also let it sweep every pin configuration code. Because the longest conversion is only 352 cycles, the bench can time each conversion exactly and still leave room for a long abort and hold window.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE, ST_ARMED, ST_SAMPLE, ST_TRIAL
  } seq_state_e;

  localparam logic [1:0] OFS_RES_LO = 2'd0;
  localparam logic [1:0] OFS_RES_HI = 2'd1;
  localparam logic [1:0] OFS_CTRL   = 2'd2;
  localparam logic [1:0] OFS_CLK    = 2'd3;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o,
  output logic       clk_o
);
  localparam int MAX_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAX_DIV = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt_q, div_m1;

  // select code 3 falls back to the slowest divider
  always_comb begin
    case (sel_q)
      2'd0:    div_m1 = CNT_W'(DIV_A - 1);
      2'd1:    div_m1 = CNT_W'(DIV_B - 1);
      default: div_m1 = CNT_W'(DIV_C - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sel_q <= sel_i;  // divider frozen for the whole conversion
    end else if (cnt_q >= div_m1) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q >= div_m1);
  assign clk_o  = run_i && (cnt_q > (div_m1 >> 1));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_m1));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_rise_i,
  input  logic             start_fall_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             eoc_o,
  output logic             busy_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o
);
  import adc_ctrl_pkg::*;
  localparam int IDX_W = $clog2(RES_W);

  seq_state_e       state_q;
  logic [RES_W-1:0] sar_q, trial_bit, trial;
  logic [IDX_W-1:0] idx_q;
  logic             eoc_q;

  assign trial_bit = RES_W'(1) << idx_q;
  assign trial     = sar_q | trial_bit;
  assign busy_o    = (state_q == ST_SAMPLE) || (state_q == ST_TRIAL);
  assign sample_o  = (state_q == ST_SAMPLE);
  assign dac_o     = (state_q == ST_TRIAL) ? trial : sar_q;
  assign done_o    = (state_q == ST_TRIAL) && tick_i && (idx_q == '0) && !start_rise_i;
  assign result_o  = cmp_i ? trial : sar_q;
  assign eoc_o     = eoc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
      eoc_q   <= 1'b0;
    end else if (start_rise_i) begin
      // a new rising edge always re-arms, aborting any running conversion
      state_q <= ST_ARMED;
      eoc_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_ARMED: if (start_fall_i) begin
          state_q <= ST_SAMPLE;
          sar_q   <= '0;
          idx_q   <= IDX_W'(RES_W - 1);
        end
        ST_SAMPLE: if (tick_i) state_q <= ST_TRIAL;
        ST_TRIAL: if (tick_i) begin
          if (cmp_i) sar_q <= trial;
          if (idx_q == '0) begin
            state_q <= ST_IDLE;
            eoc_q   <= 1'b0;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_eoc_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise_i |=> eoc_o);
  p_busy_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> eoc_o);
  p_done_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!eoc_o && !busy_o));
  p_sample_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sample_o);
endmodule

// File: rtl/adc_pin_map.sv
module adc_pin_map #(
  parameter int N_PINS = 8,
  parameter int CFG_W  = 3
) (
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [N_PINS-1:0] analog_en_o,
  output logic              power_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign analog_en_o[p] = (cfg_i != '0) && (int'(cfg_i) >= p);
  end

  assign power_o = |analog_en_o;
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl #(
  parameter logic [7:0] BASE_ADDR = 8'h24,
  parameter int         RES_W     = 10,
  parameter int         N_PINS    = 8,
  parameter int         DIV_A     = 2,
  parameter int         DIV_B     = 8,
  parameter int         DIV_C     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              sample_o,
  output logic              adc_clk_o,
  output logic [2:0]        chan_sel_o,
  output logic [N_PINS-1:0] analog_en_o,
  output logic              adc_power_o
);
  import adc_ctrl_pkg::*;
  localparam int LO_W  = RES_W - 8;
  localparam int CFG_W = $clog2(N_PINS);

  logic [7:0]       ofs_full;
  logic [1:0]       ofs;
  logic             hit, wr_ctrl, wr_clk;
  logic [2:0]       chan_q;
  logic [CFG_W-1:0] cfg_q;
  logic             start_q, test_q;
  logic [1:0]       clk_sel_q;
  logic [RES_W-1:0] res_q, result;
  logic             start_rise, start_fall, tick, eoc, busy, done;

  assign ofs_full = addr_i - BASE_ADDR;
  assign hit      = ofs_full < 8'd4;
  assign ofs      = ofs_full[1:0];
  assign wr_ctrl  = we_i && hit && (ofs == OFS_CTRL);
  assign wr_clk   = we_i && hit && (ofs == OFS_CLK);

  assign start_rise = wr_ctrl &&  wdata_i[7] && !start_q;
  assign start_fall = wr_ctrl && !wdata_i[7] &&  start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q    <= '0;
      cfg_q     <= '0;
      start_q   <= 1'b0;
      clk_sel_q <= '0;
      test_q    <= 1'b0;
      res_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        chan_q  <= wdata_i[2:0];
        cfg_q   <= wdata_i[3 +: CFG_W];
        start_q <= wdata_i[7];
      end
      if (wr_clk) begin
        clk_sel_q <= wdata_i[1:0];
        test_q    <= wdata_i[7];
      end
      if (done) res_q <= result;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (ofs)
        OFS_RES_LO: rdata_o = {res_q[LO_W-1:0], {(8-LO_W){1'b0}}};
        OFS_RES_HI: rdata_o = res_q[RES_W-1 -: 8];
        OFS_CTRL:   rdata_o = {start_q, eoc, cfg_q, chan_q};
        default:    rdata_o = {test_q, 5'b0, clk_sel_q};
      endcase
    end
  end

  adc_clk_div #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sel_i  (clk_sel_q),
    .tick_o (tick),
    .clk_o  (adc_clk_o)
  );

  adc_sar_seq #(.RES_W(RES_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_rise_i (start_rise),
    .start_fall_i (start_fall),
    .tick_i       (tick),
    .cmp_i        (cmp_i),
    .eoc_o        (eoc),
    .busy_o       (busy),
    .sample_o     (sample_o),
    .done_o       (done),
    .dac_o        (dac_code_o),
    .result_o     (result)
  );

  adc_pin_map #(.N_PINS(N_PINS), .CFG_W(CFG_W)) u_pins (
    .cfg_i       (cfg_q),
    .analog_en_o (analog_en_o),
    .power_o     (adc_power_o)
  );

  assign chan_sel_o = chan_q;

  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(res_q));
endmodule

// File: tb/adc_ctrl_test.sv
`timescale 1ns/1ps
module adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0;
  logic [9:0] dac_code;
  logic       sample_o, adc_clk_o, adc_power_o, cmp;
  logic [2:0] chan_sel_o;
  logic [7:0] analog_en_o;
  int         vin = 0;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign cmp = (vin >= int'(dac_code));

  adc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .cmp_i(cmp), .dac_code_o(dac_code), .sample_o(sample_o),
    .adc_clk_o(adc_clk_o), .chan_sel_o(chan_sel_o), .analog_en_o(analog_en_o),
    .adc_power_o(adc_power_o)
  );

  function automatic int exp_div(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
  endfunction

  function automatic int exp_pins(input int cfg);
    int m = 0;
    for (int p = 0; p < 8; p++) if (cfg != 0 && p <= cfg) m |= (1 << p);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_conv(input int vin_v, input int sel, input int cfg, input int chan, input int hold);
    logic [7:0] v, old_hi, old_lo;
    int d, n, samp, rises;
    logic prev, hi_ok;
    d = exp_div(sel);
    wr(8'h27, 8'(sel));
    rd(8'h25, old_hi);
    rd(8'h24, old_lo);
    vin = vin_v;
    wr(8'h26, {2'b10, 3'(cfg), 3'(chan)});
    rd(8'h26, v);
    chk(v[6] == 1'b1, "R3", v[6], 1);
    chk(int'(chan_sel_o) == chan, "R10", chan_sel_o, chan);
    repeat (hold) @(negedge clk);
    rd(8'h26, v);
    chk(v[6] == 1'b1, "R4", v[6], 1);
    rd(8'h25, v);
    chk(v == old_hi, "R4", v, old_hi);
    wr(8'h26, {2'b00, 3'(cfg), 3'(chan)});
    n = 0; samp = 0; rises = 0; prev = adc_clk_o; hi_ok = 1'b1;
    forever begin
      if (sample_o) samp++;
      if (adc_clk_o && !prev) rises++;
      prev = adc_clk_o;
      rd(8'h26, v);
      if (!v[6] || n > 5000) break;
      rd(8'h25, v);
      if (v != old_hi) hi_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n == 11 * d, "R5", n, 11 * d);
    chk(samp == d, "R9", samp, d);
    chk(rises == 11, "R11", rises, 11);
    chk(hi_ok, "R7", hi_ok, 1);
    @(negedge clk);
    rd(8'h25, v);
    chk(int'(v) == (vin_v >> 2), "R6", v, vin_v >> 2);
    rd(8'h24, v);
    chk(int'(v) == ((vin_v & 3) << 6), "R1", v, (vin_v & 3) << 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state and address map
    for (int a = 8'h23; a <= 8'h28; a++) begin
      rd(8'(a), v);
      chk(v == 8'h00, "R1", v, 0);
      @(negedge clk);
    end
    chk(analog_en_o == 8'h00 && !adc_power_o, "R10", analog_en_o, 0);
    chk(!adc_clk_o, "R11", adc_clk_o, 0);

    // clock register: unused bits read 0, test bit kept
    wr(8'h27, 8'hFF);
    rd(8'h27, v);
    chk(v == 8'h83, "R1", v, 8'h83);

    // read-only locations ignore writes
    wr(8'h24, 8'hFF);
    wr(8'h25, 8'hFF);
    rd(8'h24, v);
    chk(v == 8'h00, "R2", v, 0);
    rd(8'h25, v);
    chk(v == 8'h00, "R2", v, 0);
    wr(8'h26, 8'h45);
    rd(8'h26, v);
    chk(v == 8'h05, "R2", v, 8'h05);

    // pin configuration sweep
    for (int c = 0; c < 8; c++) begin
      wr(8'h26, 8'(c << 3));
      chk(int'(analog_en_o) == exp_pins(c), "R10", analog_en_o, exp_pins(c));
      chk(adc_power_o == (c != 0), "R10", adc_power_o, c != 0);
    end

    // directed conversions: code extremes, mid-scale, all selects
    run_conv(0,    0, 1, 0, 1);
    run_conv(1023, 1, 7, 7, 3);
    run_conv(512,  2, 3, 2, 2);
    run_conv(511,  3, 0, 5, 4);

    // abort by a new rising edge mid-conversion
    wr(8'h27, 8'h02);
    vin = 700;
    wr(8'h26, 8'h80);
    wr(8'h26, 8'h00);
    repeat (40) @(negedge clk);
    wr(8'h26, 8'h80);
    rd(8'h26, v);
    chk(v[6] == 1'b1, "R8", v[6], 1);
    repeat (400) @(negedge clk);
    rd(8'h26, v);
    chk(v[6] == 1'b1, "R8", v[6], 1);
    rd(8'h25, v);
    chk(v == 8'h7F, "R8", v, 8'h7F);
    vin = 300;
    wr(8'h26, 8'h00);
    w = 0;
    forever begin
      rd(8'h26, v);
      if (!v[6] || w > 2000) break;
      @(negedge clk);
      w++;
    end
    chk(w == 352, "R8", w, 352);
    @(negedge clk);
    rd(8'h25, v);
    chk(int'(v) == (300 >> 2), "R8", v, 300 >> 2);

    // random conversions
    for (int i = 0; i < 12; i++) begin
      run_conv(int'($urandom % 1024), int'($urandom % 4), int'($urandom % 8),
               int'($urandom % 8), 1 + int'($urandom % 6));
    end

    finish_run();
  end
endmodule